// File: doc/BRIEF.md
# Direct-Mapped Cache Tag Store with Match

This block keeps the tag side of a direct-mapped secondary cache. The upper address bits split into an index, which selects one entry, and a tag, which is compared against the tag held in that entry. Every entry stores a tag word, a valid flag and a dirty flag. A cache controller presents an index and a tag on each clock. One cycle later the block raises an active-high match when the entry is valid and its stored tag equals the presented tag. It also reports whether that entry is dirty.

The tag travels on one bidirectional bus. When the controller drives it, the bus carries the tag to compare or to store. When the tag output enable is high, the block drives the tag of the most recently read entry back onto the same lines, so the controller can rebuild a victim address. A write enable stores the bus tag together with separate valid and dirty inputs. A clear input invalidates every entry in a single cycle. The tag store runs on its own clock, separate from any data-array clock. With `INDEX_W = 14` and `TAG_W = 12` it holds 16K entries of 12 tag bits plus the two status bits.

Top module: `cache_tag_store`

## Requirements
- R1: In the cycles after a synchronous reset (`rst` high), every entry reads as invalid: `match` and `dirty_out` are 0 for any index and tag.
- R2: At a rising edge with `tag_we` = 1, `tag_oe` = 0, `clr` = 0 and `rst` = 0, the entry at `index` takes the tag on `tag_io`, valid from `valid_in` and dirty from `dirty_in`.
- R3: The outputs after rising edge k describe the entry at the `index` sampled at edge k. This includes a write made at that same edge, so a read of a just-written index returns the new values.
- R4: After edge k, `match` is 1 exactly when the addressed entry is valid and all TAG_W stored bits equal the `tag_io` value sampled at edge k.
- R5: `dirty_out` equals the stored dirty bit of the addressed entry ANDed with its valid bit. An invalid entry is never reported dirty.
- R6: A rising edge with `clr` = 1 invalidates all entries at once. From that edge on, `match` and `dirty_out` are 0 for every entry until it is written again.
- R7: `clr` has priority over a simultaneous write. The write is dropped completely and the entry's stored tag keeps its old value.
- R8: While `tag_oe` = 1, the block drives `tag_io` with the stored tag of the entry read at the last edge. While `tag_oe` = 0, it leaves `tag_io` undriven so the controller can drive it.
- R9: A `tag_we` pulse at an edge where `tag_oe` = 1 has no effect on the entry.
- R10: A write with `valid_in` = 0 leaves the entry invalid: `match` and `dirty_out` are 0 even when the tag compares equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated tag-store clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Invalidate all entries at the next edge |
| tag_we | input | 1 | Store bus tag, valid and dirty into the indexed entry |
| tag_oe | input | 1 | Drive the last read stored tag onto `tag_io` |
| index | input | INDEX_W | Entry select taken from the address |
| valid_in | input | 1 | Valid flag to store on a write |
| dirty_in | input | 1 | Dirty flag to store on a write |
| tag_io | inout | TAG_W | Shared tag bus: compare/write tag in, stored tag out |
| match | output | 1 | Active-high hit for the entry read at the last edge |
| dirty_out | output | 1 | Dirty flag of the entry read at the last edge (valid-qualified) |

## Verification
The bench builds the block with `INDEX_W = 5` and `TAG_W = 4`, which gives 32 entries and 16 possible tags. At that size every entry can be written with its own tag and status pattern. Every entry can also be probed against every tag value, so each hit and each near-miss of the comparator is exercised. The small depth also makes it cheap to sweep all entries after a clear, and to read every stored tag back over the shared bus. The same-edge cases (write then read, clear against write, write while the block owns the bus) are each staged on chosen entries.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

  // Operation applied to the store at a clock edge; clear outranks write.
  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_WRITE = 2'd1,
    CT_CLEAR = 2'd2
  } ct_op_e;

  function automatic ct_op_e ct_decode(input logic rst, input logic clr,
                                       input logic we, input logic oe);
    if (rst)            return CT_IDLE;
    else if (clr)       return CT_CLEAR;
    else if (we && !oe) return CT_WRITE;
    else                return CT_IDLE;
  endfunction

endpackage

// File: rtl/ctag_array.sv
// Tag plus dirty storage, single port, write-first registered read.
module ctag_array #(
  parameter int INDEX_W = 10,
  parameter int WIDTH   = 13
) (
  input  logic               clk,
  input  logic               we,
  input  logic [INDEX_W-1:0] addr,
  input  logic [WIDTH-1:0]   wdata,
  output logic [WIDTH-1:0]   rdata
);
  localparam int DEPTH = 1 << INDEX_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
      rdata     <= wdata;
    end else begin
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/ctag_valid.sv
// Valid flags in flops so that a clear completes in one edge.
module ctag_valid #(
  parameter int INDEX_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               we,
  input  logic [INDEX_W-1:0] addr,
  input  logic               vin,
  output logic               vld_rd
);
  localparam int DEPTH = 1 << INDEX_W;

  logic [DEPTH-1:0] vld_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst || clr)
        vld_q[e] <= 1'b0;
      else if (we && (addr == INDEX_W'(e)))
        vld_q[e] <= vin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      vld_rd <= 1'b0;
    else if (we)
      vld_rd <= vin;
    else
      vld_rd <= vld_q[addr];
  end
endmodule

// File: rtl/ctag_match.sv
// Equality compare of stored and probe tags, qualified by valid.
module ctag_match #(
  parameter int TAG_W = 12
) (
  input  logic [TAG_W-1:0] stored_tag,
  input  logic [TAG_W-1:0] probe_tag,
  input  logic             stored_vld,
  input  logic             stored_dty,
  output logic             hit,
  output logic             dirty
);
  logic [TAG_W-1:0] bit_eq;

  for (genvar b = 0; b < TAG_W; b++) begin : g_bit
    assign bit_eq[b] = ~(stored_tag[b] ^ probe_tag[b]);
  end

  assign hit   = stored_vld & (&bit_eq);
  assign dirty = stored_vld & stored_dty;
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               tag_we,
  input  logic               tag_oe,
  input  logic [INDEX_W-1:0] index,
  input  logic               valid_in,
  input  logic               dirty_in,
  inout  wire  [TAG_W-1:0]   tag_io,
  output logic               match,
  output logic               dirty_out
);
  import ctag_pkg::*;

  localparam int ENTRY_W = TAG_W + 1;

  ct_op_e             op;
  logic               wr_en;
  logic [ENTRY_W-1:0] wr_word;
  logic [ENTRY_W-1:0] rd_word;
  logic [TAG_W-1:0]   probe_q;
  logic               vld_rd;
  logic [TAG_W-1:0]   tag_in;

  assign tag_in  = tag_io;
  assign op      = ct_decode(rst, clr, tag_we, tag_oe);
  assign wr_en   = (op == CT_WRITE);
  assign wr_word = {dirty_in, tag_in};

  always_ff @(posedge clk) begin
    if (rst) probe_q <= '0;
    else     probe_q <= tag_in;
  end

  ctag_array #(.INDEX_W(INDEX_W), .WIDTH(ENTRY_W)) u_array (
    .clk   (clk),
    .we    (wr_en),
    .addr  (index),
    .wdata (wr_word),
    .rdata (rd_word)
  );

  ctag_valid #(.INDEX_W(INDEX_W)) u_valid (
    .clk    (clk),
    .rst    (rst),
    .clr    (op == CT_CLEAR),
    .we     (wr_en),
    .addr   (index),
    .vin    (valid_in),
    .vld_rd (vld_rd)
  );

  ctag_match #(.TAG_W(TAG_W)) u_match (
    .stored_tag (rd_word[TAG_W-1:0]),
    .probe_tag  (probe_q),
    .stored_vld (vld_rd),
    .stored_dty (rd_word[TAG_W]),
    .hit        (match),
    .dirty      (dirty_out)
  );

  assign tag_io = tag_oe ? rd_word[TAG_W-1:0] : 'z;
endmodule

// File: rtl/cache_tag_store_chk.sv
module cache_tag_store_chk #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               clr,
  input logic               tag_we,
  input logic               tag_oe,
  input logic [INDEX_W-1:0] index,
  input logic               valid_in,
  input logic               dirty_in,
  input logic [TAG_W-1:0]   tag_io,
  input logic               match,
  input logic               dirty_out
);
  p_reset_clean_r1: assert property (@(posedge clk)
    $past(rst) |-> (!match && !dirty_out));

  p_clear_kills_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(clr) && !$past(rst)) |-> (!match && !dirty_out));

  p_write_hits_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(tag_we && !tag_oe && !clr && valid_in) && !$past(rst))
      |-> (match && (dirty_out == $past(dirty_in))));

  p_invalid_write_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(tag_we && !tag_oe && !clr && !valid_in) && !$past(rst))
      |-> (!match && !dirty_out));

  p_readback_bus_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(tag_we && !tag_oe && !clr) && !$past(rst) && tag_oe)
      |-> (tag_io == $past(tag_io)));
endmodule

bind cache_tag_store cache_tag_store_chk #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .tag_we    (tag_we),
  .tag_oe    (tag_oe),
  .index     (index),
  .valid_in  (valid_in),
  .dirty_in  (dirty_in),
  .tag_io    (tag_io),
  .match     (match),
  .dirty_out (dirty_out)
);

// File: tb/test_cache_tag_store.sv
module test_cache_tag_store;
  localparam int CLK_PERIOD = 10;
  localparam int IW    = 5;
  localparam int TW    = 4;
  localparam int DEPTH = 1 << IW;
  localparam int NTAG  = 1 << TW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          tag_we = 1'b0;
  logic          tag_oe = 1'b0;
  logic [IW-1:0] index = '0;
  logic          valid_in = 1'b0;
  logic          dirty_in = 1'b0;
  logic [TW-1:0] tb_tag = '0;
  wire  [TW-1:0] tag_io;
  logic          match;
  logic          dirty_out;

  assign tag_io = tag_oe ? 'z : tb_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_tag_store #(.INDEX_W(IW), .TAG_W(TW)) i_cache_tag_store (
    .clk(clk), .rst(rst), .clr(clr), .tag_we(tag_we), .tag_oe(tag_oe),
    .index(index), .valid_in(valid_in), .dirty_in(dirty_in),
    .tag_io(tag_io), .match(match), .dirty_out(dirty_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [TW-1:0] m_tag [DEPTH];
  logic          m_vld [DEPTH];
  logic          m_dty [DEPTH];
  logic [TW-1:0] last_rd;

  task automatic check(input string req, input string what,
                       input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock edge with the given inputs, model update, then check at negedge.
  task automatic step(input string req, input logic c, input logic we,
                      input logic oe, input int idx, input int tg,
                      input logic vin, input logic din, input bit chk_bus);
    logic [TW-1:0] probe;
    clr = c; tag_we = we; tag_oe = oe; index = IW'(idx);
    tb_tag = TW'(tg); valid_in = vin; dirty_in = din;
    probe = oe ? last_rd : TW'(tg);
    @(posedge clk);
    if (c) begin
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    end else if (we && !oe) begin
      m_tag[idx] = TW'(tg); m_vld[idx] = vin; m_dty[idx] = din;
    end
    last_rd = m_tag[idx];
    @(negedge clk);
    check(req, "match", TW'(match),
          TW'(m_vld[idx] && (m_tag[idx] == probe)));
    check(req, "dirty_out", TW'(dirty_out), TW'(m_vld[idx] && m_dty[idx]));
    if (chk_bus) check(req, "tag_io", tag_io, m_tag[idx]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_tag[i] = '0; m_vld[i] = 1'b0; m_dty[i] = 1'b0;
    end
    last_rd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: nothing hits after reset
    for (int i = 0; i < 4; i++) step("R1", 0, 0, 0, i * 7, i, 0, 0, 0);

    // R2 R3: fill every entry; write-first readback at the same edge
    for (int i = 0; i < DEPTH; i++)
      step("R2", 0, 1, 0, i, (i * 7 + 3) % NTAG, (i % 5) != 0, (i % 3) == 0, 0);

    // R4 R5: every entry probed against every tag value
    for (int i = 0; i < DEPTH; i++)
      for (int t = 0; t < NTAG; t++)
        step("R4", 0, 0, 0, i, t, 0, 0, 0);

    // R8: read each stored tag back over the shared bus
    for (int i = 0; i < DEPTH; i++) step("R8", 0, 0, 1, i, 0, 0, 0, 1);

    // R9: write pulse while the block owns the bus is ignored
    step("R9", 0, 1, 1, 6, 0, 0, 1, 1);
    step("R9", 0, 0, 1, 6, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 6, (6 * 7 + 3) % NTAG, 0, 0, 0);

    // R6: clear invalidates every entry in one edge
    step("R6", 1, 0, 0, 1, (1 * 7 + 3) % NTAG, 0, 0, 0);
    for (int i = 0; i < DEPTH; i++)
      step("R6", 0, 0, 0, i, (i * 7 + 3) % NTAG, 0, 0, 0);

    // R7: clear beats a simultaneous write; stored tag unchanged
    step("R7", 0, 1, 0, 4, 9, 1, 1, 0);
    step("R7", 1, 1, 0, 4, 2, 1, 1, 0);
    step("R7", 0, 0, 1, 4, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 4, 9, 0, 0, 0);
    step("R7", 0, 0, 0, 4, 2, 0, 0, 0);

    // R10: a write with valid_in low leaves the entry missing
    step("R10", 0, 1, 0, 11, 5, 0, 1, 0);
    step("R10", 0, 0, 0, 11, 5, 0, 0, 0);
    step("R10", 0, 1, 0, 11, 5, 1, 0, 0);
    step("R10", 0, 0, 0, 11, 5, 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule